// File: doc/BRIEF.md
# Instruction Pair Issue Decoder

This block sits between an instruction prefetch buffer and a microcode sequencer. It holds two slots of fixed-length 16-bit instructions, oldest in slot 0. Each cycle it decides whether the two slotted instructions may start together. When they may, it hands the sequencer one entry address that belongs to that exact combination and consumes both slots. When they may not, it hands over the entry address of the slot-0 instruction alone, and the slot-1 instruction moves up.

Pairing is decided by programmable tables, not by fixed instruction categories. The top byte of each instruction is its opcode. A first-position map turns the opcode into a small first class, and a second-position map turns it into a second class. The two classes together index a pair table, whose entry either rejects the pair or names its entry address. Any combination can be enabled, including two copies of the same opcode. The sequencer applies back-pressure with a ready level, so a long multi-cycle pair holds the next dispatch until it finishes. A flush empties the slots on taken branches or exceptions.

Top module: `pair_issue_decoder`

## Requirements
- R1: After reset both slots are empty, no dispatch is offered and every table entry is invalid, so the first instructions issue singly.
- R2: If both slots hold instructions, the slot-0 opcode has a valid first class, the slot-1 opcode has a valid second class, and the pair entry at index {first class, second class} (first class in the upper bits) is valid, then the dispatch carries count 2, that entry's address, and both instructions.
- R3: In every other case with slot 0 filled, the dispatch carries count 1 and the address equal to the slot-0 opcode (instruction bits 15:8) zero-extended to 12 bits.
- R4: Two instructions with the same opcode pair when that opcode is enabled in both position maps and its class pair is enabled.
- R5: With only slot 0 filled, a single issue is offered at once, without waiting for a partner.
- R6: Instructions are dispatched in exactly the order accepted. After a single issue the slot-1 instruction becomes the slot-0 instruction.
- R7: While `seq_ready` is low, the offered dispatch stays the same and no slot is consumed. A dispatch is taken in a cycle where `disp_valid` and `seq_ready` are both high.
- R8: A high `flush` suppresses `disp_valid`, accepts no input, and leaves both slots empty in the next cycle.
- R9: `in_take` equals the smaller of the slots free after this cycle's dispatch and the offered count. `in_cnt` values are 0, 1 or 2, and 3 counts as 2. `in_ins0` is the older of the two offered instructions and fills the lower free slot.
- R10: A write with `wr_en` high updates one entry at the next edge. `wr_sel` 0 selects the first map, 1 the second map, 2 the pair table, and 3 is ignored. `wr_data[12]` is the entry valid bit. The payload is `wr_data[2:0]` for the first class, `wr_data[3:0]` for the second class, and `wr_data[11:0]` for the pair address. `wr_idx` is the opcode for the maps and the 7-bit pair index for the pair table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_cnt | input | 2 | Number of instructions offered (0..2) |
| in_ins0 | input | 16 | Older offered instruction |
| in_ins1 | input | 16 | Younger offered instruction |
| in_take | output | 2 | Number of offered instructions accepted this cycle |
| flush | input | 1 | Empty both slots and suppress dispatch |
| seq_ready | input | 1 | Sequencer can accept a new dispatch |
| disp_valid | output | 1 | Dispatch offered |
| disp_cnt | output | 2 | Instructions issued: 1 or 2 |
| disp_addr | output | 12 | Microcode entry address |
| disp_ins0 | output | 16 | First issued instruction |
| disp_ins1 | output | 16 | Second issued instruction, zero on a single issue |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 2 | Table select |
| wr_idx | input | 8 | Table index |
| wr_data | input | 13 | Valid bit and payload |

## Verification
The assertions take for granted that `seq_ready` and `flush` are plain levels that never go unknown after reset. They also assume that a table write in the same cycle as a stall may change the offered count and address but never the offered instruction. The stimulus keeps to this. It drives every input a full half period away from the rising edge. It uses `in_cnt` values within 0 to 2, apart from one deliberate 3. It draws opcodes from a small pool, so that enabled pairs, same-opcode pairs and rejected pairs all occur often, and it mixes in random stalls, flushes and table rewrites.

// File: rtl/pid_pkg.sv
package pid_pkg;
    localparam int INS_W = 16;

    typedef struct packed {
        logic             v0;
        logic [INS_W-1:0] i0;
        logic             v1;
        logic [INS_W-1:0] i1;
    } slots_t;
endpackage

// File: rtl/pid_lut.sv
module pid_lut #(
    parameter int AW = 8,
    parameter int DW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wvld,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic          rvalid,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DEPTH-1:0] vld_q;
    logic [DW-1:0]    dat_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int k = 0; k < DEPTH; k++) dat_q[k] <= '0;
        end else if (we) begin
            vld_q[waddr] <= wvld;
            dat_q[waddr] <= wdata;
        end
    end

    assign rvalid = vld_q[raddr];
    assign rdata  = dat_q[raddr];
endmodule

// File: rtl/pid_pair_sel.sv
module pid_pair_sel #(
    parameter int OP_W = 8,
    parameter int UA_W = 12
) (
    input  logic            v0,
    input  logic            v1,
    input  logic [OP_W-1:0] op0,
    input  logic            fc_ok,
    input  logic            sc_ok,
    input  logic            pe_ok,
    input  logic [UA_W-1:0] pe_addr,
    output logic            pair,
    output logic [1:0]      cnt,
    output logic [UA_W-1:0] addr
);
    always_comb begin
        pair = v0 && v1 && fc_ok && sc_ok && pe_ok;
        cnt  = pair ? 2'd2 : 2'd1;
        addr = pair ? pe_addr : {{(UA_W-OP_W){1'b0}}, op0};
    end
endmodule

// File: rtl/pair_issue_decoder.sv
module pair_issue_decoder
    import pid_pkg::*;
#(
    parameter int OP_W = 8,
    parameter int FC_W = 3,
    parameter int SC_W = 4,
    parameter int UA_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       in_cnt,
    input  logic [INS_W-1:0] in_ins0,
    input  logic [INS_W-1:0] in_ins1,
    output logic [1:0]       in_take,
    input  logic             flush,
    input  logic             seq_ready,
    output logic             disp_valid,
    output logic [1:0]       disp_cnt,
    output logic [UA_W-1:0]  disp_addr,
    output logic [INS_W-1:0] disp_ins0,
    output logic [INS_W-1:0] disp_ins1,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [OP_W-1:0]  wr_idx,
    input  logic [UA_W:0]    wr_data
);
    localparam int PA_W = FC_W + SC_W;

    slots_t st_q, st_d;

    logic [OP_W-1:0] op0, op1;
    logic            fc_ok, sc_ok, pe_ok, pair, fire;
    logic [FC_W-1:0] fc;
    logic [SC_W-1:0] sc;
    logic [UA_W-1:0] pe_addr;
    logic [1:0]      sel_cnt;
    logic [1:0]      offered, nrem, free_slots, take;

    assign op0 = st_q.i0[INS_W-1 -: OP_W];
    assign op1 = st_q.i1[INS_W-1 -: OP_W];

    pid_lut #(.AW(OP_W), .DW(FC_W)) u_first_map (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en && wr_sel == 2'd0), .waddr(wr_idx),
        .wvld(wr_data[UA_W]), .wdata(wr_data[FC_W-1:0]),
        .raddr(op0), .rvalid(fc_ok), .rdata(fc)
    );

    pid_lut #(.AW(OP_W), .DW(SC_W)) u_second_map (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en && wr_sel == 2'd1), .waddr(wr_idx),
        .wvld(wr_data[UA_W]), .wdata(wr_data[SC_W-1:0]),
        .raddr(op1), .rvalid(sc_ok), .rdata(sc)
    );

    pid_lut #(.AW(PA_W), .DW(UA_W)) u_pair_tab (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en && wr_sel == 2'd2), .waddr(wr_idx[PA_W-1:0]),
        .wvld(wr_data[UA_W]), .wdata(wr_data[UA_W-1:0]),
        .raddr({fc, sc}), .rvalid(pe_ok), .rdata(pe_addr)
    );

    pid_pair_sel #(.OP_W(OP_W), .UA_W(UA_W)) u_sel (
        .v0(st_q.v0), .v1(st_q.v1), .op0(op0),
        .fc_ok(fc_ok), .sc_ok(sc_ok), .pe_ok(pe_ok), .pe_addr(pe_addr),
        .pair(pair), .cnt(sel_cnt), .addr(disp_addr)
    );

    assign disp_valid = st_q.v0 && !flush;
    assign disp_cnt   = sel_cnt;
    assign disp_ins0  = st_q.i0;
    assign disp_ins1  = pair ? st_q.i1 : '0;
    assign fire       = disp_valid && seq_ready;
    assign in_take    = take;

    always_comb begin
        slots_t rem;
        rem = st_q;
        if (fire) begin
            if (pair) begin
                rem = '0;
            end else begin
                rem.v0 = st_q.v1;
                rem.i0 = st_q.i1;
                rem.v1 = 1'b0;
                rem.i1 = '0;
            end
        end
        offered    = (in_cnt == 2'd3) ? 2'd2 : in_cnt;
        nrem       = {1'b0, rem.v0} + {1'b0, rem.v1};
        free_slots = 2'd2 - nrem;
        take       = flush ? 2'd0 : ((offered < free_slots) ? offered : free_slots);
        st_d       = rem;
        if (!rem.v0) begin
            if (take != 2'd0) begin
                st_d.v0 = 1'b1;
                st_d.i0 = in_ins0;
            end
            if (take == 2'd2) begin
                st_d.v1 = 1'b1;
                st_d.i1 = in_ins1;
            end
        end else if (!rem.v1 && take != 2'd0) begin
            st_d.v1 = 1'b1;
            st_d.i1 = in_ins0;
        end
        if (flush) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_SLOTS_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.v1 |-> st_q.v0); // R6
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !st_q.v0 && !st_q.v1); // R8
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !seq_ready && !flush) |=> (st_q.v0 && $stable(disp_ins0))); // R7
    AST_TAKE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_take != 2'd3) && (in_cnt != 2'd0 || in_take == 2'd0)); // R9
    AST_PAIR_HAS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_cnt == 2'd2) |-> st_q.v1); // R2
    AST_SINGLE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.v0 && !st_q.v1 && !flush) |-> (disp_valid && disp_cnt == 2'd1)); // R5
endmodule

// File: tb/tb_pair_issue_decoder.sv
`timescale 1ns/1ps
module tb_pair_issue_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  in_cnt = '0;
    logic [15:0] in_ins0 = '0, in_ins1 = '0;
    logic [1:0]  in_take;
    logic        flush = 1'b0, seq_ready = 1'b0;
    logic        disp_valid;
    logic [1:0]  disp_cnt;
    logic [11:0] disp_addr;
    logic [15:0] disp_ins0, disp_ins1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [7:0]  wr_idx = '0;
    logic [12:0] wr_data = '0;

    pair_issue_decoder dut (
        .clk(clk), .rst_n(rst_n), .in_cnt(in_cnt), .in_ins0(in_ins0), .in_ins1(in_ins1),
        .in_take(in_take), .flush(flush), .seq_ready(seq_ready), .disp_valid(disp_valid),
        .disp_cnt(disp_cnt), .disp_addr(disp_addr), .disp_ins0(disp_ins0), .disp_ins1(disp_ins1),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    always #2 clk = ~clk;

    int errors = 0, checks = 0;
    bit finished = 0;

    // bench's own tables and slot model
    bit        fv [256];
    bit [2:0]  fcl [256];
    bit        sv [256];
    bit [3:0]  scl [256];
    bit        pv [128];
    bit [11:0] pa [128];
    logic [15:0] mq [2];
    int        mcnt = 0;
    logic [15:0] strm [8192];
    int        sp = 0;
    bit        pw_en = 0;
    bit [1:0]  pw_sel = 0;
    bit [7:0]  pw_idx = 0;
    bit [12:0] pw_data = 0;
    bit        e_valid;
    int        e_cnt;
    bit [11:0] e_addr;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_pair();
        bit [7:0] o0, o1;
        o0 = mq[0][15:8];
        o1 = mq[1][15:8];
        return mcnt == 2 && fv[o0] && sv[o1] && pv[{fcl[o0], scl[o1]}];
    endfunction

    task automatic cyc(bit f, bit rdy, int n);
        int offered, used, rem, take;
        bit pr;
        @(negedge clk);
        flush = f; seq_ready = rdy; in_cnt = 2'(n);
        in_ins0 = strm[sp]; in_ins1 = strm[sp+1];
        wr_en = pw_en; wr_sel = pw_sel; wr_idx = pw_idx; wr_data = pw_data;
        #1;
        pr = exp_pair();
        e_valid = (mcnt > 0) && !f;
        e_cnt = pr ? 2 : 1;
        e_addr = pr ? pa[{fcl[mq[0][15:8]], scl[mq[1][15:8]]}] : {4'd0, mq[0][15:8]};
        chk(f ? "R8 valid" : "R7 valid", 32'(disp_valid), 32'(e_valid));
        if (e_valid) begin
            chk("R2 cnt", 32'(disp_cnt), 32'(e_cnt));
            chk("R3 addr", 32'(disp_addr), 32'(e_addr));
            chk("R6 ins0", 32'(disp_ins0), 32'(mq[0]));
            if (pr) chk("R6 ins1", 32'(disp_ins1), 32'(mq[1]));
        end
        used = (e_valid && rdy) ? e_cnt : 0;
        rem = mcnt - used;
        offered = (n > 2) ? 2 : n;
        take = f ? 0 : ((offered < 2 - rem) ? offered : 2 - rem);
        chk("R9 take", 32'(in_take), 32'(take));
        // model update
        if (f) mcnt = 0;
        else begin
            if (used == 1) mq[0] = mq[1];
            mcnt = rem;
            for (int k = 0; k < take; k++) begin
                mq[mcnt] = strm[sp + k];
                mcnt++;
            end
        end
        sp += take;
        if (pw_en) begin
            case (pw_sel)
                2'd0: begin fv[pw_idx] = pw_data[12]; fcl[pw_idx] = pw_data[2:0]; end
                2'd1: begin sv[pw_idx] = pw_data[12]; scl[pw_idx] = pw_data[3:0]; end
                2'd2: begin pv[pw_idx[6:0]] = pw_data[12]; pa[pw_idx[6:0]] = pw_data[11:0]; end
                default: ;
            endcase
        end
        pw_en = 0;
    endtask

    task automatic twr(bit [1:0] s, bit [7:0] i, bit [12:0] d);
        pw_en = 1; pw_sel = s; pw_idx = i; pw_data = d;
        cyc(0, 0, 0);
    endtask

    function automatic logic [15:0] rins();
        return {8'h20 + 8'($urandom % 10), 8'($urandom)};
    endfunction

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        report();
    end

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < 8192; k++) strm[k] = rins();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 reset valid", 32'(disp_valid), 0);
        chk("R1 reset take", 32'(in_take), 0);

        // R1: tables empty, a pairable-looking pair issues singly
        strm[sp] = 16'h4011; strm[sp+1] = 16'h4022;
        cyc(0, 0, 2);
        cyc(0, 1, 0);
        chk("R1 single before program", 32'(e_cnt), 1);
        chk("R1 dut cnt", 32'(disp_cnt), 1);
        cyc(0, 1, 0);

        // R4/R10: program same-opcode pair 0x40,0x40 -> class 5,9 -> 0xABC
        twr(2'd0, 8'h40, {1'b1, 12'd5});
        twr(2'd1, 8'h40, {1'b1, 12'd9});
        twr(2'd2, {1'b0, 3'd5, 4'd9}, {1'b1, 12'hABC});
        twr(2'd3, {1'b0, 3'd5, 4'd9}, 13'd0); // R10 sel 3 must be ignored
        strm[sp] = 16'h4033; strm[sp+1] = 16'h4044;
        cyc(0, 0, 3);
        cyc(0, 1, 0);
        chk("R4 same-op pair cnt", 32'(disp_cnt), 2);
        chk("R10 pair addr after sel3", 32'(disp_addr), 32'hABC);

        // R5: lone instruction issues at once
        strm[sp] = 16'h4055;
        cyc(0, 1, 1);
        cyc(0, 1, 0);
        chk("R5 lone valid", 32'(disp_valid), 1);
        chk("R5 lone cnt", 32'(disp_cnt), 1);
        chk("R3 lone addr", 32'(disp_addr), 32'h040);

        // R8: flush with occupied slots
        strm[sp] = 16'h4066; strm[sp+1] = 16'h2177;
        cyc(0, 0, 2);
        cyc(1, 1, 2);
        cyc(0, 0, 0);
        chk("R8 empty after flush", 32'(disp_valid), 0);

        // random tables
        for (int k = 0; k < 10; k++) begin
            twr(2'd0, 8'h20 + 8'(k), {1'($urandom % 4 != 0), 9'd0, 3'($urandom)});
            twr(2'd1, 8'h20 + 8'(k), {1'($urandom % 4 != 0), 8'd0, 4'($urandom)});
        end
        for (int k = 0; k < 128; k++)
            twr(2'd2, 8'(k), {1'($urandom % 3 != 0), 12'($urandom)});

        // random mix
        while (sp < 8000) begin
            if ($urandom % 40 == 0)
                pw_en = 1;
            if (pw_en) begin
                pw_sel = 2'($urandom);
                pw_idx = (pw_sel == 2'd2) ? 8'($urandom % 128) : 8'h20 + 8'($urandom % 10);
                pw_data = {1'($urandom % 3 != 0), 12'($urandom)};
            end
            cyc($urandom % 50 == 0, $urandom % 4 != 0, $urandom % 3);
        end
        report();
    end
endmodule